// File: doc/BRIEF.md
# Per-Drive Perpendicular Recording Mode Selector

This block holds the perpendicular recording mode setting of a floppy disk controller and turns it, together with the drive and data rate of the current access, into the recording parameters that access needs. A single-cycle write strobe loads a command parameter byte. The byte carries two global mode bits (a gap bit and a write-gate bit), an overwrite enable, and one perpendicular enable bit for each of four drives.

When both global bits are zero, each drive's own enable bit decides its mode. Accesses can then move between conventional and perpendicular drives without the command being issued again. When either global bit is set, the global pair alone fixes the mode for every drive.

The outputs are combinational from the held bits, the 2-bit drive select and the 2-bit data rate code:
- whether the access is perpendicular;
- the GAP2 field length;
- how many GAP2 bytes the write-data operation writes itself;
- whether write precompensation is forced to zero.

A software reset clears only the global pair. The active-low hardware reset clears everything.

Top module: `perp_mode_select`

## Requirements
- R1: While the hardware reset `rstN` is low and after it is released, the gap bit, the write-gate bit and all drive enable bits are 0. Every access then reads as conventional: `isPerp`=0, `gap2Len`=22, `gap2Written`=0, `precompZero`=0.
- R2: A `cmdWrite` pulse with `cmdByte[7]`=1 (overwrite) loads the following bits, taking effect from the next clock edge:
  - the gap bit from `cmdByte[1]`;
  - the write-gate bit from `cmdByte[0]`;
  - the enable bit of drive i from `cmdByte[2+i]`.
  `cmdByte[6]` has no effect.
- R3: A `cmdWrite` pulse with `cmdByte[7]`=0 loads the gap and write-gate bits but leaves every drive enable bit unchanged.
- R4: A `swReset` pulse clears the gap and write-gate bits at the next edge and leaves every drive enable bit unchanged.
- R5: When `swReset` and `cmdWrite` are high in the same cycle, the gap and write-gate bits end at 0. The drive enable bits follow the write under the rules of R2 and R3.
- R6: When the gap bit or the write-gate bit is set, the drive enable bits are ignored and every drive reads the same way:
  - gap=1, write-gate=0: perpendicular, 22/19;
  - gap=0, write-gate=1: conventional, 22/0;
  - both bits 1: perpendicular, 41/38.
  Each pair is written as `gap2Len`/`gap2Written`.
- R7: With both global bits 0, a drive whose enable bit is 0 reads as conventional, 22/0.
- R8: With both global bits 0, a drive whose enable bit is 1 reads as perpendicular. The rate code is 00=500K, 01=300K, 10=250K, 11=1M. Code 11 gives 41/38; any other code gives 22/19.
- R9: `precompZero` is 1 exactly when the access reads as perpendicular.
- R10: The outputs follow `driveSel` and `rateCode` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| swReset | input | 1 | Software reset pulse |
| cmdWrite | input | 1 | Single-cycle parameter byte write strobe |
| cmdByte | input | 8 | Command parameter byte |
| driveSel | input | 2 | Drive of the current access |
| rateCode | input | 2 | Programmed data rate code |
| isPerp | output | 1 | Access uses perpendicular recording |
| gap2Len | output | 6 | GAP2 field length in bytes |
| gap2Written | output | 6 | GAP2 bytes written by the write-data operation |
| precompZero | output | 1 | Write precompensation forced to 0 ns |

## Verification
A software reset and a parameter write can land in the same cycle. In that cycle the global bits must end cleared, while the drive bits obey the write's overwrite flag. The bench provokes this in a directed case with overwrite set and with it clear, and again through random strobes that overlap often. The behavioural reference model applies the same priority, and its prediction is compared on every cycle for every drive select and rate the stimulus reaches.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGlobal;   // capture gap / write-gate bits
    logic loadDrives;   // capture per-drive enable bits
    logic clearGlobal;  // software reset of gap / write-gate
  } pmStrobe_t;

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int OW_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic             swReset,
  input  logic [CMD_W-1:0] cmdByte,
  output pmStrobe_t        strobe
);

  // Software reset outranks a write for the global pair; the drive
  // bits still follow the write's overwrite flag.
  always_comb begin
    strobe.clearGlobal = swReset;
    strobe.loadGlobal  = cmdWrite & ~swReset;
    strobe.loadDrives  = cmdWrite & cmdByte[OW_BIT];
  end

  // R5: a simultaneous software reset never lets the global pair load
  a_r5_sw_beats_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && swReset) |-> (strobe.clearGlobal && !strobe.loadGlobal));

  // R3: drive bits load only with overwrite set
  a_r3_ow_gates_drives: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDrives |-> (cmdWrite && cmdByte[OW_BIT]));

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int          NUM_DRIVES = 4,
  parameter int          CMD_W      = 8,
  parameter int          DRV_LSB    = 2,
  parameter int          GAP_BIT    = 1,
  parameter int          WG_BIT     = 0,
  parameter int          RATE_W     = 2,
  parameter int          CNT_W      = 6,
  parameter int          LEN_STD    = 22,
  parameter int          WR_STD     = 19,
  parameter int          LEN_HI     = 41,
  parameter int          WR_HI      = 38,
  parameter logic [RATE_W-1:0] RATE_TOP = 2'b11,
  localparam int         SEL_W      = $clog2(NUM_DRIVES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmStrobe_t         strobe,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic [SEL_W-1:0]  driveSel,
  input  logic [RATE_W-1:0] rateCode,
  output logic              isPerp,
  output logic [CNT_W-1:0]  gap2Len,
  output logic [CNT_W-1:0]  gap2Written,
  output logic              precompZero
);

  localparam logic [CNT_W-1:0] LEN_STD_C = CNT_W'(LEN_STD);
  localparam logic [CNT_W-1:0] WR_STD_C  = CNT_W'(WR_STD);
  localparam logic [CNT_W-1:0] LEN_HI_C  = CNT_W'(LEN_HI);
  localparam logic [CNT_W-1:0] WR_HI_C   = CNT_W'(WR_HI);
  localparam logic [CNT_W-1:0] GAP_DIFF  = CNT_W'(LEN_STD - WR_STD);

  logic                  gapQ;
  logic                  wgateQ;
  logic [NUM_DRIVES-1:0] driveQ;

  // Global pair: hardware reset clears, software reset clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapQ   <= 1'b0;
      wgateQ <= 1'b0;
    end else if (strobe.clearGlobal) begin
      gapQ   <= 1'b0;
      wgateQ <= 1'b0;
    end else if (strobe.loadGlobal) begin
      gapQ   <= cmdByte[GAP_BIT];
      wgateQ <= cmdByte[WG_BIT];
    end
  end

  // Per-drive enables: only hardware reset clears them
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 driveQ[d] <= 1'b0;
      else if (strobe.loadDrives) driveQ[d] <= cmdByte[DRV_LSB + d];
    end
  end

  logic selBit;
  logic highRate;
  assign selBit   = driveQ[driveSel];
  assign highRate = (rateCode == RATE_TOP);

  always_comb begin
    isPerp      = 1'b0;
    gap2Len     = LEN_STD_C;
    gap2Written = '0;
    unique case ({wgateQ, gapQ})
      2'b01: begin
        isPerp      = 1'b1;
        gap2Written = WR_STD_C;
      end
      2'b10: ; // reserved, behaves as conventional
      2'b11: begin
        isPerp      = 1'b1;
        gap2Len     = LEN_HI_C;
        gap2Written = WR_HI_C;
      end
      default: begin
        if (selBit) begin
          isPerp      = 1'b1;
          gap2Len     = highRate ? LEN_HI_C : LEN_STD_C;
          gap2Written = highRate ? WR_HI_C  : WR_STD_C;
        end
      end
    endcase
    precompZero = isPerp;
  end

  // R4: software reset alone keeps drive bits and clears the pair
  a_r4_sw_keeps_drives: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearGlobal && !strobe.loadDrives) |=> $stable(driveQ));
  a_r4_sw_clears_pair: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearGlobal |=> (!gapQ && !wgateQ));
  // R3: without a drive load the drive bits hold
  a_r3_drives_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadDrives |=> $stable(driveQ));
  // R6/R8: perpendicular GAP2 always writes all but the fixed lead bytes
  a_r6_written_vs_len: assert property (@(posedge clk) disable iff (!rstN)
    isPerp |-> (gap2Written + GAP_DIFF == gap2Len));
  // R7: a conventional access writes no GAP2 bytes
  a_r7_conv_values: assert property (@(posedge clk) disable iff (!rstN)
    !isPerp |-> (gap2Written == '0 && gap2Len == LEN_STD_C));

endmodule

// File: rtl/perp_mode_select.sv
module perp_mode_select
  import pm_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int CMD_W      = 8,
  parameter int RATE_W     = 2,
  parameter int CNT_W      = 6,
  localparam int SEL_W     = $clog2(NUM_DRIVES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              cmdWrite,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic [SEL_W-1:0]  driveSel,
  input  logic [RATE_W-1:0] rateCode,
  output logic              isPerp,
  output logic [CNT_W-1:0]  gap2Len,
  output logic [CNT_W-1:0]  gap2Written,
  output logic              precompZero
);

  pmStrobe_t strobe;

  pm_ctrl #(.CMD_W(CMD_W), .OW_BIT(CMD_W-1)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .swReset(swReset),
    .cmdByte(cmdByte), .strobe(strobe)
  );

  pm_datapath #(
    .NUM_DRIVES(NUM_DRIVES), .CMD_W(CMD_W), .RATE_W(RATE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdByte(cmdByte),
    .driveSel(driveSel), .rateCode(rateCode), .isPerp(isPerp),
    .gap2Len(gap2Len), .gap2Written(gap2Written), .precompZero(precompZero)
  );

endmodule

// File: tb/perp_mode_select_tb.sv
`timescale 1ns/1ps
module perp_mode_select_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [7:0] cmdByte = '0;
  logic [1:0] driveSel = '0;
  logic [1:0] rateCode = '0;
  logic       isPerp, precompZero;
  logic [5:0] gap2Len, gap2Written;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  int refGap = 0, refWg = 0;
  int refD[4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  perp_mode_select u_dut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .cmdWrite(cmdWrite),
    .cmdByte(cmdByte), .driveSel(driveSel), .rateCode(rateCode),
    .isPerp(isPerp), .gap2Len(gap2Len), .gap2Written(gap2Written),
    .precompZero(precompZero)
  );

  // Compare outputs against the model for the current inputs
  task automatic checkNow(string tag);
    int ePerp, eLen, eWr;
    string t;
    t = tag;
    if (refGap == 1 && refWg == 0) begin ePerp = 1; eLen = 22; eWr = 19; end
    else if (refGap == 0 && refWg == 1) begin ePerp = 0; eLen = 22; eWr = 0; end
    else if (refGap == 1 && refWg == 1) begin ePerp = 1; eLen = 41; eWr = 38; end
    else if (refD[driveSel] == 1) begin
      ePerp = 1;
      if (rateCode == 2'b11) begin eLen = 41; eWr = 38; end
      else begin eLen = 22; eWr = 19; end
    end else begin ePerp = 0; eLen = 22; eWr = 0; end
    if (t == "") begin
      if (refGap != 0 || refWg != 0) t = "R6";
      else if (refD[driveSel] == 1) t = "R8";
      else t = "R7";
    end
    checks++;
    if (isPerp !== 1'(ePerp) || gap2Len !== 6'(eLen) || gap2Written !== 6'(eWr)) begin
      errors++;
      $display("FAIL %s perp/len/wr actual %0d/%0d/%0d expected %0d/%0d/%0d (sel %0d rate %0d)",
               t, isPerp, gap2Len, gap2Written, ePerp, eLen, eWr, driveSel, rateCode);
    end
    checks++;
    if (precompZero !== 1'(ePerp)) begin
      errors++;
      $display("FAIL R9 precompZero actual %0d expected %0d", precompZero, ePerp);
    end
  endtask

  // Model update at a clock edge with the present inputs
  task automatic modelEdge();
    if (cmdWrite) begin
      if (cmdByte[7]) for (int i = 0; i < 4; i++) refD[i] = int'(cmdByte[2+i]);
      refGap = int'(cmdByte[1]);
      refWg  = int'(cmdByte[0]);
    end
    if (swReset) begin refGap = 0; refWg = 0; end
  endtask

  // One cycle: drive, check before the edge, update model after it
  task automatic step(bit wr, bit sw, logic [7:0] b, logic [1:0] sel,
                      logic [1:0] rate, string tag);
    cmdWrite = wr; swReset = sw; cmdByte = b; driveSel = sel; rateCode = rate;
    #1 checkNow(tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 4; r++)
        step(1'b0, 1'b0, 8'h00, 2'(s), 2'(r), tag);
  endtask

  initial begin
    #1 checkNow("R1");                 // during reset
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sweep("R1");
    // R2: overwrite load, drives 0 and 2 enabled, bit6 set (ignored)
    step(1'b1, 1'b0, 8'b1101_0100, 2'd0, 2'd0, "R2");
    sweep("R2");
    // R3: OW=0 with all drive bits set must not change drive bits
    step(1'b1, 1'b0, 8'b0011_1100, 2'd0, 2'd0, "R3");
    sweep("R3");
    // R6: each global combination overrides drive bits
    step(1'b1, 1'b0, 8'b0000_0010, 2'd0, 2'd0, "R6"); sweep("R6");
    step(1'b1, 1'b0, 8'b0000_0001, 2'd0, 2'd0, "R6"); sweep("R6");
    step(1'b1, 1'b0, 8'b0000_0011, 2'd0, 2'd0, "R6"); sweep("R6");
    // R4: software reset clears the pair, drive bits stay (0 and 2)
    step(1'b0, 1'b1, 8'h00, 2'd0, 2'd0, "R4");
    sweep("R4");
    // R5: overlap with OW=1: drives load, pair ends cleared
    step(1'b1, 1'b1, 8'b1010_1011, 2'd0, 2'd0, "R5");
    sweep("R5");
    // R5: overlap with OW=0: drives keep, pair ends cleared
    step(1'b1, 1'b1, 8'b0011_1111, 2'd0, 2'd0, "R5");
    sweep("R5");
    // R10: outputs track select and rate within one cycle
    step(1'b1, 1'b0, 8'b1000_0100, 2'd0, 2'd0, "R10");
    driveSel = 2'd0; rateCode = 2'd3; #0.3 checkNow("R10");
    rateCode = 2'd1;                  #0.3 checkNow("R10");
    driveSel = 2'd1;                  #0.3 checkNow("R10");
    @(negedge clk);
    // Random phase with frequent overlaps, compared every cycle
    for (int n = 0; n < 600; n++)
      step(($urandom % 3) == 0, ($urandom % 5) == 0, 8'($urandom),
           2'($urandom), 2'($urandom), "");
    // R1: hardware reset mid-run clears drive bits too
    step(1'b1, 1'b0, 8'b1011_1111, 2'd0, 2'd0, "R2");
    rstN = 1'b0;
    refGap = 0; refWg = 0; refD = '{0, 0, 0, 0};
    #1 checkNow("R1");
    @(negedge clk);
    rstN = 1'b1;
    sweep("R1");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule